// File: doc/BRIEF.md
# SPI ADC Single-Conversion Sequencer

This block is the master side of an SPI link to an external eight-channel analog-to-digital converter. A one-cycle start pulse with a 3-bit channel index begins one conversion. The block lowers chip select and shifts out a four-byte command. The first byte names the result register of the chosen channel. The second byte is a read of the conversion-command register. The last two bytes are zero padding.

After the command, the serial clock stays idle for a fixed conversion gap, counted in system clocks. The block then clocks in a two-byte reply, most significant bit first. Once the last reply bit has been clocked in, it releases chip select. It keeps the ten upper bits of the reply as the sample and shows them with a one-cycle done strobe and a valid flag. The sample is held until the next accepted start.

The serial link runs in SPI mode 0. The clock idles low. The slave samples MOSI on the rising SCLK edge, and MOSI changes only on the falling edge. The block samples MISO on the rising edge. The SCLK half period is a whole number of system clocks, set by a parameter.

Top module: `spi_conv_seq`

## Requirements
- R1: After reset, csN=1, sclk=0, mosi=0, busy=0, done=0 and resultValid=0.
- R2: The first command byte on MOSI (bits 31:24 of the 32-bit command word, first bit sent is bit 31) equals 0x10 plus the channel index.
- R3: The second command byte (bits 23:16) equals 0x8E: the register address 0x0E in bits 5:0 and the read flag in bit 7.
- R4: The command phase is exactly 32 SCLK cycles, and bits 15:0 of the command word are zero.
- R5: SCLK idles low. Each SCLK phase lasts SCLK_HALF system clocks, so rising edges within a phase are 2*SCLK_HALF clocks apart. MOSI does not change while SCLK is high.
- R6: Between the last command falling edge and the first readback rising edge, SCLK stays low for DELAY_CYCLES + SCLK_HALF system clocks. DELAY_CYCLES = CLK_FREQ_HZ/1e6 * GAP_US, which is 600 at the defaults.
- R7: The readback phase is 16 SCLK cycles with MISO taken MSB first. The result equals bits 15:6 of the received word.
- R8: csN is low from the cycle after an accepted start through the whole frame, with 48 rising SCLK edges in total. It rises in the same cycle as done, and SCLK is never high while csN is high.
- R9: done is high for exactly one cycle per conversion, with resultValid high. result and resultValid then hold until the next accepted start.
- R10: A start while busy is ignored. The frame in flight keeps its channel, and no second frame follows it.
- R11: An accepted start clears resultValid in the following cycle and sets busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle conversion request |
| chanIdx | input | 3 | Channel to convert, sampled with start |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| csN | output | 1 | Chip select, active low |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion strobe |
| resultValid | output | 1 | Result holds a completed sample |
| result | output | 10 | Extracted 10-bit sample |

## Verification
The assertions assume that MISO is already synchronous to the system clock. They also assume it settles before the system clock edge on which SCLK rises, so the MOSI-stability and result-hold properties involve no metastability. The bench's converter model meets this by updating MISO only on falling SCLK edges and by driving start from the falling system clock edge. The sweep covers every channel with several reply words, including all-zeros and all-ones. During some frames it also pulses start again with a different channel, to show that the request has no effect.

// File: rtl/spi_conv_pkg.sv
package spi_conv_pkg;
  localparam logic [7:0] RESULT_REG_BASE = 8'h10;
  localparam logic [5:0] CONV_CMD_REG    = 6'h0E;
  localparam logic       READ_FLAG       = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_GAP  = 2'd2,
    ST_READ = 2'd3
  } seqState_t;

  typedef struct packed {
    logic load;
    logic shiftTx;
    logic sampleRx;
    logic finish;
  } seqStrobes_t;
endpackage

// File: rtl/spi_conv_ctrl.sv
module spi_conv_ctrl
  import spi_conv_pkg::*;
#(
  parameter int SCLK_HALF    = 2,
  parameter int DELAY_CYCLES = 600,
  parameter int CMD_BITS     = 32,
  parameter int RD_BITS      = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output seqStrobes_t strb,
  output logic        sclk,
  output logic        csN,
  output logic        busy
);
  localparam int DIV_W  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int GAP_W  = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam int MAXB   = (CMD_BITS > RD_BITS) ? CMD_BITS : RD_BITS;
  localparam int BIT_W  = (MAXB > 1) ? $clog2(MAXB) : 1;

  seqState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             sclkQ;
  logic             csNQ;
  logic             tick;
  logic             lastCmd;
  logic             lastRd;

  always_comb begin
    tick    = (divCnt == DIV_W'(SCLK_HALF - 1));
    lastCmd = (bitCnt == BIT_W'(CMD_BITS - 1));
    lastRd  = (bitCnt == BIT_W'(RD_BITS - 1));
    strb.load     = (state == ST_IDLE) && start;
    strb.shiftTx  = (state == ST_CMD)  && tick && sclkQ;
    strb.sampleRx = (state == ST_READ) && tick && !sclkQ;
    strb.finish   = (state == ST_READ) && tick && sclkQ && lastRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      gapCnt <= '0;
      bitCnt <= '0;
      sclkQ  <= 1'b0;
      csNQ   <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_CMD;
            csNQ   <= 1'b0;
            divCnt <= '0;
            bitCnt <= '0;
            sclkQ  <= 1'b0;
          end
        end
        ST_CMD, ST_READ: begin
          if (tick) begin
            divCnt <= '0;
            sclkQ  <= !sclkQ;
            if (sclkQ) begin
              if (state == ST_CMD) begin
                if (lastCmd) begin
                  state  <= ST_GAP;
                  gapCnt <= '0;
                  bitCnt <= '0;
                end else begin
                  bitCnt <= bitCnt + 1'b1;
                end
              end else begin
                if (lastRd) begin
                  state <= ST_IDLE;
                  csNQ  <= 1'b1;
                  bitCnt <= '0;
                end else begin
                  bitCnt <= bitCnt + 1'b1;
                end
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gapCnt == GAP_W'(DELAY_CYCLES - 1)) begin
            state  <= ST_READ;
            divCnt <= '0;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk = sclkQ;
  assign csN  = csNQ;
  assign busy = (state != ST_IDLE);

  p_sclk_needs_cs_r8: assert property (@(posedge clk) disable iff (!rstN)
    sclkQ |-> !csNQ);
  p_gap_sclk_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> (!sclkQ && !csNQ));
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (state != ST_CMD || $past(state) == ST_CMD));
endmodule

// File: rtl/spi_conv_dp.sv
module spi_conv_dp
  import spi_conv_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int CMD_BITS = 32,
  parameter int RD_BITS  = 16,
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strb,
  input  logic [CH_W-1:0]     chanIdx,
  input  logic                miso,
  output logic                mosi,
  output logic [RES_BITS-1:0] result,
  output logic                resultValid,
  output logic                done
);
  localparam int PAD_BITS = CMD_BITS - 16;

  logic [CMD_BITS-1:0] frame;
  logic [CMD_BITS-1:0] txShift;
  logic [RD_BITS-1:0]  rxShift;
  logic [RES_BITS-1:0] resQ;
  logic                validQ;
  logic                doneQ;

  always_comb begin
    frame[CMD_BITS-1 -: 8] = RESULT_REG_BASE + 8'(chanIdx);
    frame[CMD_BITS-9 -: 8] = {READ_FLAG, 1'b0, CONV_CMD_REG};
  end

  generate
    if (PAD_BITS > 0) begin : g_pad
      assign frame[PAD_BITS-1:0] = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      resQ    <= '0;
      validQ  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= strb.finish;
      if (strb.load) begin
        txShift <= frame;
        validQ  <= 1'b0;
      end else if (strb.shiftTx) begin
        txShift <= {txShift[CMD_BITS-2:0], 1'b0};
      end
      if (strb.sampleRx) begin
        rxShift <= {rxShift[RD_BITS-2:0], miso};
      end
      if (strb.finish) begin
        resQ   <= rxShift[RD_BITS-1 -: RES_BITS];
        validQ <= 1'b1;
      end
    end
  end

  assign mosi        = txShift[CMD_BITS-1];
  assign result      = resQ;
  assign resultValid = validQ;
  assign done        = doneQ;

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  p_done_with_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> validQ);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && $past(validQ) && !$past(strb.load)) |-> $stable(resQ));
  p_valid_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !validQ);
endmodule

// File: rtl/spi_conv_seq.sv
module spi_conv_seq
  import spi_conv_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int GAP_US      = 6,
  parameter int SCLK_HALF   = 2,
  parameter int CH_W        = 3,
  parameter int CMD_BYTES   = 4,
  parameter int RD_BYTES    = 2,
  parameter int RES_BITS    = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [CH_W-1:0]     chanIdx,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                csN,
  output logic                busy,
  output logic                done,
  output logic                resultValid,
  output logic [RES_BITS-1:0] result
);
  localparam int DELAY_CYCLES = (CLK_FREQ_HZ / 1_000_000) * GAP_US;
  localparam int CMD_BITS     = CMD_BYTES * 8;
  localparam int RD_BITS      = RD_BYTES * 8;

  seqStrobes_t strb;

  spi_conv_ctrl #(
    .SCLK_HALF   (SCLK_HALF),
    .DELAY_CYCLES(DELAY_CYCLES),
    .CMD_BITS    (CMD_BITS),
    .RD_BITS     (RD_BITS)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .strb (strb),
    .sclk (sclk),
    .csN  (csN),
    .busy (busy)
  );

  spi_conv_dp #(
    .CH_W    (CH_W),
    .CMD_BITS(CMD_BITS),
    .RD_BITS (RD_BITS),
    .RES_BITS(RES_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .chanIdx    (chanIdx),
    .miso       (miso),
    .mosi       (mosi),
    .result     (result),
    .resultValid(resultValid),
    .done       (done)
  );

  p_mosi_stable_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
  p_cs_release_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> done);
endmodule

// File: tb/spi_conv_seq_tb.sv
module spi_conv_seq_tb;
  localparam int HALF  = 2;
  localparam int DELAY = 600;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [2:0] chanIdx = '0;
  logic       miso = 1'b0;
  logic       sclk, mosi, csN, busy, done, resultValid;
  logic [9:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int        cyc = 0;
  int        edgeCnt = 0;
  logic [31:0] cmdWord = '0;
  logic [15:0] respWord = '0;
  int        tRise0 = 0, tRise1 = 0, tFall32 = 0, tRise32 = 0;
  int        edgesAtRelease = 0;

  always #5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  spi_conv_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .chanIdx(chanIdx), .miso(miso),
    .sclk(sclk), .mosi(mosi), .csN(csN), .busy(busy), .done(done),
    .resultValid(resultValid), .result(result)
  );

  // converter model: frame start clears the edge count, rising edges count
  always @(negedge csN or posedge sclk) begin
    if (sclk) begin
      if (edgeCnt < 32) cmdWord = {cmdWord[30:0], mosi};
      if (edgeCnt == 0) tRise0 = cyc;
      if (edgeCnt == 1) tRise1 = cyc;
      if (edgeCnt == 32) tRise32 = cyc;
      edgeCnt = edgeCnt + 1;
    end else begin
      edgeCnt = 0;
    end
  end

  always @(negedge sclk) begin
    if (edgeCnt == 32) tFall32 = cyc;
    if (edgeCnt >= 32 && edgeCnt < 48) miso = respWord[47 - edgeCnt];
  end

  always @(posedge csN) edgesAtRelease = edgeCnt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic runConv(input int ch, input logic [15:0] resp, input bit inject);
    bit seen = 0;
    int lastRes;
    respWord = resp;
    @(negedge clk);
    start = 1'b1;
    chanIdx = 3'(ch);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && resultValid == 1'b0, "R11 start accepted", {busy, resultValid}, 2'b10);
    chk(csN == 1'b0, "R8 cs low after start", csN, 0);
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (inject && i == 100) begin start = 1'b1; chanIdx = 3'(ch) ^ 3'd5; end
      if (inject && i == 101) start = 1'b0;
      if (done) seen = 1;
    end
    chk(seen, "R9 done seen", seen, 1);
    chk(resultValid == 1'b1, "R9 valid with done", resultValid, 1);
    chk(csN == 1'b1, "R8 cs released with done", csN, 1);
    chk(result == resp[15:6], "R7 result bits 15:6", result, resp[15:6]);
    chk(cmdWord[31:24] == 8'(8'h10 + ch), "R2 first byte", cmdWord[31:24], 8'h10 + ch);
    chk(cmdWord[23:16] == 8'h8E, "R3 second byte", cmdWord[23:16], 8'h8E);
    chk(cmdWord[15:0] == 16'h0, "R4 padding bytes", cmdWord[15:0], 0);
    chk(edgesAtRelease == 48, "R8 R4 edge count", edgesAtRelease, 48);
    chk(tRise1 - tRise0 == 2 * HALF, "R5 sclk period", tRise1 - tRise0, 2 * HALF);
    chk(tRise32 - tFall32 == DELAY + HALF, "R6 gap length", tRise32 - tFall32, DELAY + HALF);
    lastRes = int'(result);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0 && csN == 1'b1 && sclk == 1'b0, "R10 no second frame",
        {busy, csN, sclk}, 3'b010);
    chk(int'(result) == lastRes && resultValid, "R9 result held", result, lastRes);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 reset pins", {csN, sclk, mosi}, 3'b100);
    chk(busy == 1'b0 && done == 1'b0 && resultValid == 1'b0, "R1 reset status",
        {busy, done, resultValid}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int ch = 0; ch < 8; ch++) begin
      for (int p = 0; p < 3; p++) begin
        logic [15:0] r;
        r = 16'((ch * 37 + p * 911 + 5) * 40503);
        runConv(ch, r, p == 1);
      end
    end
    runConv(7, 16'hFFFF, 1'b0);
    runConv(0, 16'h0000, 1'b1);
    runConv(3, 16'h003F, 1'b0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule